// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between a host register interface and a memory-card command engine. The host loads a 32-bit argument, then writes an 11-bit command word. When that word has its enable bit set and neither unsupported mode bit is set, the block issues the command: for one cycle it presents the command index and argument on the card port. It then collects the reply, which the card side delivers as a stream of bytes followed by a completion strobe.

When the completion strobe arrives, the block checks the number of bytes against what the command word asked for. A valid reply is written big-endian into four 32-bit response words. The block then sets one of three sticky flags: command sent, response received or timeout. The enable bit of the stored command word clears itself, so a host that reads the word back can see that the command has finished. The flags stay set until the host clears them with a mask write, and the response words keep their values until the next valid response replaces them.

Top module: `mci_cmd_issue`

## Requirements
- R1: After reset all flags are 0, all response words are 0, `busy` is 0, `card_cmd_valid` is 0 and the command readback is 0.
- R2: A command write with bit 10 (enable) set, bit 8 (interrupt mode) clear and bit 9 (pending mode) clear raises `card_cmd_valid` for exactly one cycle, starting the cycle after the write. During that cycle `card_cmd_index` equals write bits 5:0 and `card_cmd_arg` equals the last written argument.
- R3: On the completion strobe that ends a command, bit 10 of `cmd_word_rd` returns to 0 and `busy` falls. Bits 9:0 keep their written values.
- R4: If bit 6 (response expected) is clear, a completion without card error sets `flag_sent`, whatever the byte count.
- R5: If bit 6 is set, a completion without error is accepted when the count is 16, or when the count is 4 and bit 7 (long response) is clear. An accepted reply sets `flag_resp`. Any other count, including zero, sets `flag_tmo`.
- R6: Response bytes are packed big-endian. Byte 0 lands in bits 31:24 of word 0, and word k of a 16-byte reply holds bytes 4k to 4k+3. Word k appears on `resp_words[32k+31:32k]`.
- R7: An accepted 4-byte reply sets words 1 to 3 to zero. An accepted 16-byte reply has bit 0 of word 3 forced to 0.
- R8: A completion with `card_rsp_err` high sets `flag_tmo`, whatever the byte count.
- R9: A command write with the enable bit set and bit 8 or bit 9 set issues nothing. The stored word reads back with its enable bit already 0, and no flag changes.
- R10: Flags are sticky. A clear write drops the flags selected by the mask (bit 0 sent, bit 1 response, bit 2 timeout). A flag set in the same cycle as a clear stays set.
- R11: Command writes made while `busy` is high are ignored.
- R12: A completion that sets `flag_tmo` leaves the response words unchanged.
- R13: A byte delivered in the same cycle as the completion strobe is counted and packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_we | input | 1 | Command word write strobe |
| host_cmd_wdata | input | 11 | Command word |
| host_arg_we | input | 1 | Argument write strobe |
| host_arg_wdata | input | 32 | Argument value |
| host_clr_we | input | 1 | Flag clear strobe |
| host_clr_mask | input | 3 | Flags to clear: bit 0 sent, bit 1 response, bit 2 timeout |
| cmd_word_rd | output | 11 | Stored command word |
| busy | output | 1 | A command is in flight |
| card_cmd_valid | output | 1 | One-cycle command issue strobe |
| card_cmd_index | output | 6 | Command index |
| card_cmd_arg | output | 32 | Command argument |
| card_rsp_byte_valid | input | 1 | Response byte valid |
| card_rsp_byte | input | 8 | Response byte |
| card_rsp_done | input | 1 | Reply complete |
| card_rsp_err | input | 1 | Card-side error, qualified by done |
| resp_words | output | 128 | Four response words, word 0 in the low bits |
| flag_sent | output | 1 | Command sent without response |
| flag_resp | output | 1 | Response received |
| flag_tmo | output | 1 | Command timeout |

## Verification
The issue strobe appears one cycle after the write edge. Flags, response words, `busy` and the cleared enable bit all change on the edge that samples the completion strobe. The bench drives every input on the falling edge and samples on the falling edge that follows the relevant rising edge. It therefore reads the issue strobe half a cycle after the write edge, and reads the results half a cycle after the completion edge. A write made while busy and a rejected mode write are checked at the readback one cycle after the write.

// File: rtl/mci_cmd_pkg.sv
`timescale 1ns/1ps
package mci_cmd_pkg;
  localparam int IDX_W    = 6;
  localparam int RSP_BIT  = 6;
  localparam int LONG_BIT = 7;
  localparam int INT_BIT  = 8;
  localparam int PEND_BIT = 9;
  localparam int EN_BIT   = 10;
  localparam int CMD_W    = 11;

  localparam int FLG_SENT = 0;
  localparam int FLG_RESP = 1;
  localparam int FLG_TMO  = 2;
  localparam int NFLAGS   = 3;

  typedef struct packed {
    logic             enable;
    logic             mode_pend;
    logic             mode_int;
    logic             want_long;
    logic             want_rsp;
    logic [IDX_W-1:0] idx;
  } cmd_fields_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ctrl_state_t;
endpackage

// File: rtl/mci_cmd_decode.sv
`timescale 1ns/1ps
module mci_cmd_decode
  import mci_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_fields_t      fields_o,
  output logic             issue_ok_o
);
  always_comb begin
    fields_o.idx       = word_i[IDX_W-1:0];
    fields_o.want_rsp  = word_i[RSP_BIT];
    fields_o.want_long = word_i[LONG_BIT];
    fields_o.mode_int  = word_i[INT_BIT];
    fields_o.mode_pend = word_i[PEND_BIT];
    fields_o.enable    = word_i[EN_BIT];
    issue_ok_o = word_i[EN_BIT] & ~word_i[INT_BIT] & ~word_i[PEND_BIT];
  end
endmodule

// File: rtl/mci_rsp_shift.sv
`timescale 1ns/1ps
module mci_rsp_shift #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 16,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     capture_i,
  input  logic                     byte_valid_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic [NBYTES*BYTE_W-1:0] nxt_data_o,
  output logic [CNT_W-1:0]         nxt_cnt_o
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              upd;

  always_comb begin
    nxt_data_o = data_q;
    nxt_cnt_o  = cnt_q;
    upd        = 1'b0;
    if (clear_i) begin
      nxt_data_o = '0;
      nxt_cnt_o  = '0;
      upd        = 1'b1;
    end else if (capture_i && byte_valid_i) begin
      nxt_data_o = {data_q[DATA_W-BYTE_W-1:0], byte_i};
      nxt_cnt_o  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      upd        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      data_q <= nxt_data_o;
      cnt_q  <= nxt_cnt_o;
    end
  end

  // R13
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !clear_i && byte_valid_i && cnt_q != CNT_MAX) |=> (cnt_q != '0));
endmodule

// File: rtl/mci_cmd_ctrl.sv
`timescale 1ns/1ps
module mci_cmd_ctrl
  import mci_cmd_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_cmd_we,
  input  logic [CMD_W-1:0]         host_cmd_wdata,
  input  logic                     host_arg_we,
  input  logic [ARG_W-1:0]         host_arg_wdata,
  input  logic                     host_clr_we,
  input  logic [NFLAGS-1:0]        host_clr_mask,
  input  logic                     rsp_done_i,
  input  logic                     rsp_err_i,
  input  logic [NWORDS*WORD_W-1:0] sh_data_i,
  input  logic [CNT_W-1:0]         sh_cnt_i,
  output logic [CMD_W-1:0]         cmd_word_o,
  output logic [IDX_W-1:0]         cmd_idx_o,
  output logic [ARG_W-1:0]         arg_o,
  output logic                     busy_o,
  output logic                     issue_o,
  output logic                     shift_clear_o,
  output logic                     shift_capture_o,
  output logic [NWORDS*WORD_W-1:0] resp_o,
  output logic [NFLAGS-1:0]        flags_o
);
  localparam int SHORT_LEN = WORD_W / BYTE_W;
  localparam int LONG_LEN  = NWORDS * SHORT_LEN;

  cmd_fields_t wr_fields, cmd_q, cmd_d;
  logic        wr_issue_ok;
  ctrl_state_t st_q, st_d;
  logic [NFLAGS-1:0] flags_q, flags_d;
  logic [ARG_W-1:0]  arg_q;
  logic [NWORDS-1:0][WORD_W-1:0] resp_q, resp_new;
  logic resp_we, len_short_ok, len_long_ok;

  mci_cmd_decode u_dec (
    .word_i     (host_cmd_wdata),
    .fields_o   (wr_fields),
    .issue_ok_o (wr_issue_ok)
  );

  assign len_short_ok = (sh_cnt_i == CNT_W'(SHORT_LEN)) && !cmd_q.want_long;
  assign len_long_ok  = (sh_cnt_i == CNT_W'(LONG_LEN));

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    flags_d = flags_q;
    resp_we = 1'b0;
    if (host_clr_we) flags_d = flags_q & ~host_clr_mask;
    unique case (st_q)
      ST_IDLE: begin
        if (host_cmd_we) begin
          cmd_d = wr_fields;
          if (wr_issue_ok) st_d = ST_ISSUE;
          else cmd_d.enable = 1'b0;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_done_i) begin
          st_d = ST_IDLE;
          cmd_d.enable = 1'b0;
          if (rsp_err_i) flags_d[FLG_TMO] = 1'b1;
          else if (!cmd_q.want_rsp) flags_d[FLG_SENT] = 1'b1;
          else if (len_short_ok || len_long_ok) begin
            flags_d[FLG_RESP] = 1'b1;
            resp_we = 1'b1;
          end else flags_d[FLG_TMO] = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cmd_q   <= '0;
      flags_q <= '0;
      arg_q   <= '0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      flags_q <= flags_d;
      if (host_arg_we) arg_q <= host_arg_wdata;
    end
  end

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic [WORD_W-1:0] long_word;
    if (gi == NWORDS - 1) begin : g_last
      assign long_word = sh_data_i[(NWORDS-1-gi)*WORD_W +: WORD_W] & ~WORD_W'(1);
    end else begin : g_mid
      assign long_word = sh_data_i[(NWORDS-1-gi)*WORD_W +: WORD_W];
    end
    if (gi == 0) begin : g_first
      assign resp_new[gi] = len_long_ok ? long_word : sh_data_i[WORD_W-1:0];
    end else begin : g_rest
      assign resp_new[gi] = len_long_ok ? long_word : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_q[gi] <= '0;
      else if (resp_we) resp_q[gi] <= resp_new[gi];
    end
  end

  assign cmd_word_o      = cmd_q;
  assign cmd_idx_o       = cmd_q.idx;
  assign arg_o           = arg_q;
  assign busy_o          = (st_q != ST_IDLE);
  assign issue_o         = (st_q == ST_ISSUE);
  assign shift_clear_o   = (st_q == ST_ISSUE);
  assign shift_capture_o = (st_q == ST_WAIT);
  assign resp_o          = resp_q;
  assign flags_o         = flags_q;

  // R2
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);
  // R3
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !cmd_word_o[EN_BIT]);
  // R5
  resp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[FLG_RESP]) |-> $past(rsp_done_i));
  // R7
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_o[(NWORDS-1)*WORD_W] == 1'b0);
  // R8
  err_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_capture_o && rsp_done_i && rsp_err_i) |=> flags_o[FLG_TMO]);
  // R10
  sticky_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[FLG_SENT] && !(host_clr_we && host_clr_mask[FLG_SENT])) |=> flags_o[FLG_SENT]);
  // R11
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_capture_o && !rsp_done_i && host_cmd_we) |=> $stable(cmd_word_o));
  // R12
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_capture_o && rsp_done_i && rsp_err_i) |=> $stable(resp_o));
endmodule

// File: rtl/mci_cmd_issue.sv
`timescale 1ns/1ps
module mci_cmd_issue
  import mci_cmd_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_cmd_we,
  input  logic [CMD_W-1:0]         host_cmd_wdata,
  input  logic                     host_arg_we,
  input  logic [ARG_W-1:0]         host_arg_wdata,
  input  logic                     host_clr_we,
  input  logic [NFLAGS-1:0]        host_clr_mask,
  output logic [CMD_W-1:0]         cmd_word_rd,
  output logic                     busy,
  output logic                     card_cmd_valid,
  output logic [IDX_W-1:0]         card_cmd_index,
  output logic [ARG_W-1:0]         card_cmd_arg,
  input  logic                     card_rsp_byte_valid,
  input  logic [BYTE_W-1:0]        card_rsp_byte,
  input  logic                     card_rsp_done,
  input  logic                     card_rsp_err,
  output logic [NWORDS*WORD_W-1:0] resp_words,
  output logic                     flag_sent,
  output logic                     flag_resp,
  output logic                     flag_tmo
);
  localparam int NBYTES = NWORDS * WORD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 2);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sh_clear, sh_capture;
  logic [NBYTES*BYTE_W-1:0] sh_data;
  logic [CNT_W-1:0]         sh_cnt;
  logic [NFLAGS-1:0]        flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mci_rsp_shift #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .clear_i      (sh_clear),
    .capture_i    (sh_capture),
    .byte_valid_i (card_rsp_byte_valid),
    .byte_i       (card_rsp_byte),
    .nxt_data_o   (sh_data),
    .nxt_cnt_o    (sh_cnt)
  );

  mci_cmd_ctrl #(.ARG_W(ARG_W), .WORD_W(WORD_W), .NWORDS(NWORDS),
                 .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .host_cmd_we     (host_cmd_we),
    .host_cmd_wdata  (host_cmd_wdata),
    .host_arg_we     (host_arg_we),
    .host_arg_wdata  (host_arg_wdata),
    .host_clr_we     (host_clr_we),
    .host_clr_mask   (host_clr_mask),
    .rsp_done_i      (card_rsp_done),
    .rsp_err_i       (card_rsp_err),
    .sh_data_i       (sh_data),
    .sh_cnt_i        (sh_cnt),
    .cmd_word_o      (cmd_word_rd),
    .cmd_idx_o       (card_cmd_index),
    .arg_o           (card_cmd_arg),
    .busy_o          (busy),
    .issue_o         (card_cmd_valid),
    .shift_clear_o   (sh_clear),
    .shift_capture_o (sh_capture),
    .resp_o          (resp_words),
    .flags_o         (flags)
  );

  assign flag_sent = flags[FLG_SENT];
  assign flag_resp = flags[FLG_RESP];
  assign flag_tmo  = flags[FLG_TMO];
endmodule

// File: tb/mci_cmd_issue_tb_top.sv
`timescale 1ns/1ps
module mci_cmd_issue_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic host_cmd_we, host_arg_we, host_clr_we;
  logic [10:0] host_cmd_wdata;
  logic [31:0] host_arg_wdata;
  logic [2:0]  host_clr_mask;
  logic [10:0] cmd_word_rd;
  logic busy, card_cmd_valid;
  logic [5:0]  card_cmd_index;
  logic [31:0] card_cmd_arg;
  logic card_rsp_byte_valid, card_rsp_done, card_rsp_err;
  logic [7:0]  card_rsp_byte;
  logic [127:0] resp_words;
  logic flag_sent, flag_resp, flag_tmo;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  logic [2:0]   exp_flags;
  logic [127:0] exp_words;
  logic [7:0]   bq [0:23];

  always #4 clk = ~clk;

  mci_cmd_issue dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_cmd_we(host_cmd_we), .host_cmd_wdata(host_cmd_wdata),
    .host_arg_we(host_arg_we), .host_arg_wdata(host_arg_wdata),
    .host_clr_we(host_clr_we), .host_clr_mask(host_clr_mask),
    .cmd_word_rd(cmd_word_rd), .busy(busy),
    .card_cmd_valid(card_cmd_valid), .card_cmd_index(card_cmd_index),
    .card_cmd_arg(card_cmd_arg),
    .card_rsp_byte_valid(card_rsp_byte_valid), .card_rsp_byte(card_rsp_byte),
    .card_rsp_done(card_rsp_done), .card_rsp_err(card_rsp_err),
    .resp_words(resp_words),
    .flag_sent(flag_sent), .flag_resp(flag_resp), .flag_tmo(flag_tmo)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_word(input int base);
    return {bq[base], bq[base+1], bq[base+2], bq[base+3]};
  endfunction

  // expected outcome from requirements R4, R5, R6, R7, R8, R12
  task automatic model(input logic [10:0] w, input int n, input bit err);
    if (err) exp_flags[2] = 1'b1;
    else if (!w[6]) exp_flags[0] = 1'b1;
    else if (n == 16) begin
      exp_flags[1] = 1'b1;
      exp_words = {pack_word(12) & 32'hFFFF_FFFE, pack_word(8), pack_word(4), pack_word(0)};
    end else if (n == 4 && !w[7]) begin
      exp_flags[1] = 1'b1;
      exp_words = {96'h0, pack_word(0)};
    end else exp_flags[2] = 1'b1;
  endtask

  task automatic run_cmd(input logic [10:0] w, input logic [31:0] arg, input int n,
                         input bit err, input bit with_last, input bit clr_at_done);
    @(negedge clk);
    host_arg_we = 1'b1; host_arg_wdata = arg;
    @(negedge clk);
    host_arg_we = 1'b0;
    host_cmd_we = 1'b1; host_cmd_wdata = w;
    @(negedge clk);
    host_cmd_we = 1'b0;
    chk("R2 valid", {127'h0, card_cmd_valid}, 128'h1);
    chk("R2 index", {122'h0, card_cmd_index}, {122'h0, w[5:0]});
    chk("R2 arg", {96'h0, card_cmd_arg}, {96'h0, arg});
    @(negedge clk);
    chk("R2 pulse width", {127'h0, card_cmd_valid}, 128'h0);
    for (int i = 0; i < n; i++) begin
      card_rsp_byte_valid = 1'b1; card_rsp_byte = bq[i];
      if (with_last && i == n - 1) begin
        card_rsp_done = 1'b1; card_rsp_err = err;
      end
      @(negedge clk);
    end
    card_rsp_byte_valid = 1'b0;
    if (!(with_last && n > 0)) begin
      card_rsp_done = 1'b1; card_rsp_err = err;
      if (clr_at_done) begin host_clr_we = 1'b1; host_clr_mask = 3'b111; exp_flags = 3'b000; end
      @(negedge clk);
    end
    card_rsp_done = 1'b0; card_rsp_err = 1'b0;
    host_clr_we = 1'b0;
    model(w, n, err);
    chk("R3 enable cleared", {117'h0, cmd_word_rd}, {117'h0, 1'b0, w[9:0]});
    chk("R3 busy low", {127'h0, busy}, 128'h0);
    chk("R4 R5 R8 R10 flags", {125'h0, flag_tmo, flag_resp, flag_sent}, {125'h0, exp_flags});
    chk("R6 R7 R12 words", resp_words, exp_words);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    host_cmd_we = 0; host_arg_we = 0; host_clr_we = 0;
    host_cmd_wdata = '0; host_arg_wdata = '0; host_clr_mask = '0;
    card_rsp_byte_valid = 0; card_rsp_byte = '0; card_rsp_done = 0; card_rsp_err = 0;
    exp_flags = '0; exp_words = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 flags", {125'h0, flag_tmo, flag_resp, flag_sent}, 128'h0);
    chk("R1 words", resp_words, 128'h0);
    chk("R1 busy/valid", {126'h0, busy, card_cmd_valid}, 128'h0);
    chk("R1 cmd readback", {117'h0, cmd_word_rd}, 128'h0);

    // R5 R6 R7 directed long reply, last byte with odd value
    for (int i = 0; i < 16; i++) bq[i] = 8'(8'h10 + i);
    bq[15] = 8'hFF;
    run_cmd(11'h4C2, 32'hDEAD_BEEF, 16, 1'b0, 1'b0, 1'b0);
    chk("R7 last bit", {127'h0, resp_words[96]}, 128'h0);
    chk("R6 first byte", {120'h0, resp_words[31:24]}, {120'h0, 8'h10});

    // R5 4-byte reply to long request -> timeout, R12 words kept
    run_cmd(11'h4C5, 32'h1, 4, 1'b0, 1'b0, 1'b0);
    // R5 zero length with response expected
    run_cmd(11'h443, 32'h2, 0, 1'b0, 1'b0, 1'b0);
    // R7 short reply zeroes words 1..3, R13 last byte with done
    for (int i = 0; i < 4; i++) bq[i] = 8'(8'hA0 + i);
    run_cmd(11'h447, 32'h3, 4, 1'b0, 1'b1, 1'b0);
    // R4 no response, nonzero count
    run_cmd(11'h409, 32'h4, 3, 1'b0, 1'b0, 1'b0);
    // R8 card error with valid length
    run_cmd(11'h44A, 32'h5, 4, 1'b1, 1'b0, 1'b0);
    // R10 clear all at done cycle: new flag stays
    run_cmd(11'h40B, 32'h6, 0, 1'b0, 1'b0, 1'b1);

    // R9 interrupt and pending modes not issued
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      host_cmd_we = 1'b1; host_cmd_wdata = (m == 0) ? 11'h54C : 11'h64C;
      @(negedge clk);
      host_cmd_we = 1'b0;
      chk("R9 no issue", {126'h0, card_cmd_valid, busy}, 128'h0);
      chk("R9 readback", {117'h0, cmd_word_rd}, {117'h0, (m == 0) ? 11'h14C : 11'h24C});
      chk("R9 flags", {125'h0, flag_tmo, flag_resp, flag_sent}, {125'h0, exp_flags});
    end

    // R10 partial clear
    @(negedge clk);
    host_clr_we = 1'b1; host_clr_mask = 3'b001;
    @(negedge clk);
    host_clr_we = 1'b0;
    exp_flags[0] = 1'b0;
    chk("R10 partial clear", {125'h0, flag_tmo, flag_resp, flag_sent}, {125'h0, exp_flags});

    // R11 write while busy ignored
    @(negedge clk);
    host_cmd_we = 1'b1; host_cmd_wdata = 11'h40D;
    @(negedge clk);
    host_cmd_we = 1'b0;
    @(negedge clk);
    host_cmd_we = 1'b1; host_cmd_wdata = 11'h43F;
    @(negedge clk);
    host_cmd_we = 1'b0;
    chk("R11 readback", {117'h0, cmd_word_rd}, {117'h0, 11'h40D});
    card_rsp_done = 1'b1;
    @(negedge clk);
    card_rsp_done = 1'b0;
    exp_flags[0] = 1'b1;
    chk("R11 completes original", {125'h0, flag_tmo, flag_resp, flag_sent}, {125'h0, exp_flags});

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [10:0] w;
      int n;
      int pick;
      bit err;
      w = {1'b1, 2'b00, 8'($urandom)};
      pick = int'($urandom % 6);
      n = (pick == 0) ? 0 : (pick == 1 || pick == 4) ? 4 : (pick == 5) ? int'($urandom % 21) : 16;
      err = ($urandom % 8) == 0;
      for (int i = 0; i < 24; i++) bq[i] = 8'($urandom);
      if (($urandom % 4) == 0) begin
        logic [2:0] cm;
        cm = 3'($urandom);
        @(negedge clk);
        host_clr_we = 1'b1; host_clr_mask = cm;
        @(negedge clk);
        host_clr_we = 1'b0;
        exp_flags = exp_flags & ~cm;
      end
      run_cmd(w, $urandom, n, err, ($urandom % 2) == 1, 1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule